// File: doc/BRIEF.md
# Slice-based line-change timestamp engine

This block watches a bank of input lines grouped into slices of 32. Each slice has its own mask that marks which lines take part. When any enabled line in a slice changes level, the engine captures three things as one event: the free-running 64-bit tick count, the slice's value from before the change and its value after the change. One event can cover several lines, because the lines that moved are the bits where the two values differ (XOR).

Events go into a 32-entry queue. Software drains the queue over a small 32-bit register bus, one register per head field. It checks the queue fill level in the status word, reads the head fields and then writes a command to discard the head. A level interrupt is high while the queue holds at least a programmable number of events. One tick is one cycle of the block clock, which is meant to run at 31.25 MHz, so software multiplies ticks by 32 (shift left 5) to get nanoseconds.

A three-state machine drives the interrupt:
- ENG_OFF: the engine is stopped.
- ENG_ARMED: the engine is running and the fill level is below the threshold.
- ENG_ALERT: the engine is running and the fill level is at or above the threshold.

Its transitions are:
- OFF to ARMED on start when the level is below the threshold.
- OFF to ALERT on start when the level is at or above it.
- ARMED to ALERT when the level reaches the threshold.
- ALERT to ARMED when pops take the level below it.
- ARMED to OFF and ALERT to OFF when the engine is stopped.

Top module: `linechg_stamp_top`

## Requirements
- R1: After reset, the control word (0x00) reads 0x0000_0100: engine off, interrupt off, threshold 1. The status word (0x20) reads 0, every slice mask reads 0, and `irq_o` is low.
- R2: With the engine running (control bit 0), a level change on an enabled line pushes one entry. Its slice index reads in source word 0x0C bits 23:16, its new slice value at 0x10 and its old slice value at 0x14.
- R3: A change on a line whose mask bit is 0, or a change made while the engine is stopped, pushes no entry. Starting the engine again does not report such earlier changes.
- R4: Lines of one slice that change together produce a single entry, and the XOR of words 0x10 and 0x14 equals the set of changed lines.
- R5: When several slices have an event in the same cycle, they are queued one per cycle with the lowest slice index first, and they carry equal timestamps.
- R6: The tick counter advances by one each clock. The head timestamp reads as a high word at 0x04 and a low word at 0x08. Two changes N cycles apart on the same slice give timestamps that differ by exactly N.
- R7: Writing a value with bit 0 set to the command word 0x1C drops the head entry, and the head words then show the next entry. A drop while the queue is empty has no effect.
- R8: Status bits 15:8 give the number of queued entries.
- R9: The queue holds 32 entries. An event that arrives while it is full is lost, and status bit 0 is set and stays set until software writes 1 to it at 0x20.
- R10: `irq_o` is high exactly while the engine is running, interrupt enable (control bit 1) is set, and the fill level is at or above the threshold in control bits 15:8. It falls once drops bring the level below the threshold.
- R11: The mask of slice s sits at byte offset 0x40 + 32*s, one bit per line (bit i is line 32*s + i), and reads back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the timestamp tick |
| rst_n | input | 1 | Active-low asynchronous reset |
| lines_i | input | NUM_SLICES*32 | Asynchronous watched lines, line id = 32*slice + bit |
| reg_addr_i | input | 8 | Register byte address |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
If the captured reference for a slice is wrong, the next event read at 0x14 shows an old value that does not match the last value delivered. A stale reference also produces false entries once the engine is restarted, and both show up within a handful of cycles of the change. Faults in the queue pointers or the fill counter show up as a wrong fill level at 0x20 or out-of-order timestamps, visible right after the next pop. A faulty interrupt state machine shows as `irq_o` sitting at the wrong level two cycles after the fill level crosses the threshold.

// File: rtl/lcs_pkg.sv
`timescale 1ns/1ps
package lcs_pkg;
    localparam int SLICE_W = 32;
    localparam int TS_W    = 64;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_TS_HI  = 8'h04;
    localparam logic [7:0] OFS_TS_LO  = 8'h08;
    localparam logic [7:0] OFS_SRC    = 8'h0C;
    localparam logic [7:0] OFS_CUR    = 8'h10;
    localparam logic [7:0] OFS_PREV   = 8'h14;
    localparam logic [7:0] OFS_CMD    = 8'h1C;
    localparam logic [7:0] OFS_STAT   = 8'h20;
    localparam int         MASK_BASE  = 'h40;
    localparam int         MASK_STEP  = 'h20;

    typedef struct packed {
        logic [TS_W-1:0]    stamp;
        logic [7:0]         slice;
        logic [SLICE_W-1:0] prev;
        logic [SLICE_W-1:0] cur;
    } evt_t;

    typedef enum logic [1:0] {
        ENG_OFF   = 2'd0,
        ENG_ARMED = 2'd1,
        ENG_ALERT = 2'd2
    } eng_state_t;
endpackage

// File: rtl/lcs_slice_watch.sv
`timescale 1ns/1ps
module lcs_slice_watch
    import lcs_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [SLICE_W-1:0] lines_raw,
    input  logic [SLICE_W-1:0] en_mask,
    input  logic [TS_W-1:0]    stamp,
    input  logic               grant,
    output logic               pending,
    output evt_t               snap
);
    logic [SLICE_W-1:0] sync1_q, sync2_q, ref_q;
    logic               pend_q;
    evt_t               snap_q;
    logic               hit;

    // two-flop synchronizer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            sync1_q <= lines_raw;
            sync2_q <= sync1_q;
        end
    end

    assign hit = run && !pend_q && (|((sync2_q ^ ref_q) & en_mask));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            ref_q  <= '0;
            snap_q <= '0;
        end else if (!run) begin
            pend_q <= 1'b0;
            ref_q  <= sync2_q;
        end else if (hit) begin
            pend_q       <= 1'b1;
            snap_q.stamp <= stamp;
            snap_q.slice <= 8'(IDX);
            snap_q.prev  <= ref_q;
            snap_q.cur   <= sync2_q;
            ref_q        <= sync2_q;
        end else if (pend_q) begin
            if (grant) pend_q <= 1'b0;
        end else begin
            ref_q <= sync2_q;
        end
    end

    assign pending = pend_q;
    assign snap    = snap_q;
endmodule

// File: rtl/lcs_event_fifo.sv
`timescale 1ns/1ps
module lcs_event_fifo
    import lcs_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  evt_t             din,
    input  logic             pop,
    output evt_t             head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    evt_t             mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= nxt(wr_q);
            if (do_pop)  rd_q <= nxt(rd_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign head  = empty ? '0 : mem_q[rd_q];
    assign count = cnt_q;
endmodule

// File: rtl/lcs_irq_fsm.sv
`timescale 1ns/1ps
module lcs_irq_fsm
    import lcs_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             irq_en,
    input  logic [CNT_W-1:0] count,
    input  logic [7:0]       thr,
    output logic             irq,
    output eng_state_t       state
);
    eng_state_t state_q, state_d;
    logic       above;

    assign above = (int'(count) >= int'(thr));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENG_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_OFF:   if (run) state_d = above ? ENG_ALERT : ENG_ARMED;
            ENG_ARMED: if (!run) state_d = ENG_OFF;
                       else if (above) state_d = ENG_ALERT;
            ENG_ALERT: if (!run) state_d = ENG_OFF;
                       else if (!above) state_d = ENG_ARMED;
            default:   state_d = ENG_OFF;
        endcase
    end

    always_comb begin
        irq   = (state_q == ENG_ALERT) && irq_en && run;
        state = state_q;
    end
endmodule

// File: rtl/linechg_stamp_top.sv
`timescale 1ns/1ps
module linechg_stamp_top
    import lcs_pkg::*;
#(
    parameter int NUM_SLICES = 2,
    parameter int FIFO_DEPTH = 32,
    localparam int LINES_W   = NUM_SLICES * SLICE_W,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINES_W-1:0] lines_i,
    input  logic [7:0]         reg_addr_i,
    input  logic               reg_wr_i,
    input  logic [31:0]        reg_wdata_i,
    output logic [31:0]        reg_rdata_o,
    output logic               irq_o
);
    logic               ctrl_run, ctrl_irq_en;
    logic [7:0]         ctrl_thr;
    logic [SLICE_W-1:0] mask_q [NUM_SLICES];
    logic [TS_W-1:0]    ts_q;
    logic               ovf_q;

    logic [NUM_SLICES-1:0] pend, grant;
    evt_t                  snap [NUM_SLICES];
    evt_t                  sel, head;
    logic                  push_req, pop_req, ovf_clr;
    logic [CNT_W-1:0]      fifo_count;
    logic                  fifo_full, fifo_empty;
    eng_state_t            eng_state;

    assign pop_req = reg_wr_i && (reg_addr_i == OFS_CMD) && reg_wdata_i[0];
    assign ovf_clr = reg_wr_i && (reg_addr_i == OFS_STAT) && reg_wdata_i[0];

    // control, masks, tick counter, overflow flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_run    <= 1'b0;
            ctrl_irq_en <= 1'b0;
            ctrl_thr    <= 8'd1;
            ts_q        <= '0;
            ovf_q       <= 1'b0;
            for (int s = 0; s < NUM_SLICES; s++) mask_q[s] <= '0;
        end else begin
            ts_q  <= ts_q + 1'b1;
            ovf_q <= (ovf_q && !ovf_clr) || (push_req && fifo_full);
            if (reg_wr_i && reg_addr_i == OFS_CTRL) begin
                ctrl_run    <= reg_wdata_i[0];
                ctrl_irq_en <= reg_wdata_i[1];
                ctrl_thr    <= reg_wdata_i[15:8];
            end
            for (int s = 0; s < NUM_SLICES; s++) begin
                if (reg_wr_i && reg_addr_i == 8'(MASK_BASE + s * MASK_STEP))
                    mask_q[s] <= reg_wdata_i;
            end
        end
    end

    // per-slice watchers
    for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
        lcs_slice_watch #(.IDX(g)) watch_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (ctrl_run),
            .lines_raw (lines_i[g*SLICE_W +: SLICE_W]),
            .en_mask   (mask_q[g]),
            .stamp     (ts_q),
            .grant     (grant[g]),
            .pending   (pend[g]),
            .snap      (snap[g])
        );
    end

    // fixed priority: lowest slice first
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        sel   = '0;
        for (int s = 0; s < NUM_SLICES; s++) begin
            if (pend[s] && !found) begin
                grant[s] = 1'b1;
                sel      = snap[s];
                found    = 1'b1;
            end
        end
    end
    assign push_req = |grant;

    lcs_event_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_req),
        .din   (sel),
        .pop   (pop_req),
        .head  (head),
        .count (fifo_count),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    lcs_irq_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctrl_run),
        .irq_en (ctrl_irq_en),
        .count  (fifo_count),
        .thr    (ctrl_thr),
        .irq    (irq_o),
        .state  (eng_state)
    );

    // read mux
    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            OFS_CTRL:  reg_rdata_o = {16'd0, ctrl_thr, 6'd0, ctrl_irq_en, ctrl_run};
            OFS_TS_HI: reg_rdata_o = head.stamp[63:32];
            OFS_TS_LO: reg_rdata_o = head.stamp[31:0];
            OFS_SRC:   reg_rdata_o = {8'd0, head.slice, 16'd0};
            OFS_CUR:   reg_rdata_o = head.cur;
            OFS_PREV:  reg_rdata_o = head.prev;
            OFS_STAT:  reg_rdata_o = {16'd0, 8'(fifo_count), 7'd0, ovf_q};
            default: begin
                for (int s = 0; s < NUM_SLICES; s++) begin
                    if (reg_addr_i == 8'(MASK_BASE + s * MASK_STEP))
                        reg_rdata_o = mask_q[s];
                end
            end
        endcase
    end
endmodule

// File: rtl/lcs_checker.sv
`timescale 1ns/1ps
module lcs_checker #(
    parameter int NUM_SLICES = 2,
    parameter int FIFO_DEPTH = 32,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  irq_o,
    input logic [CNT_W-1:0]      fifo_count,
    input logic [7:0]            ctrl_thr,
    input logic                  ovf_q,
    input logic                  ovf_clr,
    input logic                  push_req,
    input logic                  pop_req,
    input logic [NUM_SLICES-1:0] grant
);
    // R10: interrupt only when the level reached the threshold last cycle
    p_irq_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (int'($past(fifo_count)) >= int'($past(ctrl_thr))));

    // R9: fill level never exceeds depth
    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_count) <= FIFO_DEPTH);

    // R9: overflow flag is sticky until cleared
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ovf_clr) |=> ovf_q);

    // R9: push into a full queue raises overflow
    p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && int'(fifo_count) == FIFO_DEPTH) |=> ovf_q);

    // R7: a lone pop on a non-empty queue lowers the level by one
    p_pop_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && fifo_count != '0) |=>
            (fifo_count == $past(fifo_count) - 1'b1));

    // R5: at most one slice served per cycle
    p_grant_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
endmodule

bind linechg_stamp_top lcs_checker #(
    .NUM_SLICES (NUM_SLICES),
    .FIFO_DEPTH (FIFO_DEPTH)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_o      (irq_o),
    .fifo_count (fifo_count),
    .ctrl_thr   (ctrl_thr),
    .ovf_q      (ovf_q),
    .ovf_clr    (ovf_clr),
    .push_req   (push_req),
    .pop_req    (pop_req),
    .grant      (grant)
);

// File: tb/linechg_stamp_top_tb_top.sv
`timescale 1ns/1ps
module linechg_stamp_top_tb_top;
    localparam int NS = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS*32-1:0] lines = '0;
    logic [7:0]    addr = '0;
    logic          wr = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    linechg_stamp_top #(.NUM_SLICES(NS), .FIFO_DEPTH(32)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .lines_i     (lines),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; wr = 1'b0;
        #1 d = rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] occ(input logic [31:0] st);
        return {24'd0, st[15:8]};
    endfunction

    task automatic pop();
        bus_wr(8'h1C, 32'h1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_rd(8'h00, d); check("R1 ctrl", d, 32'h100);
        bus_rd(8'h20, d); check("R1 status", d, 0);
        bus_rd(8'h40, d); check("R1 mask0", d, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_masks();
        logic [31:0] d;
        bus_wr(8'h40, 32'hFFFF_FFFF);
        bus_wr(8'h60, 32'h0000_00F0);
        bus_rd(8'h40, d); check("R11 mask0", d, 32'hFFFF_FFFF);
        bus_rd(8'h60, d); check("R11 mask1", d, 32'h0000_00F0);
    endtask

    task automatic t_single();
        logic [31:0] d;
        bus_wr(8'h00, 32'h0000_0401);
        wait_cyc(4);
        @(negedge clk); lines[3] = 1'b1;
        wait_cyc(8);
        bus_rd(8'h20, d); check("R8 level one", occ(d), 1);
        bus_rd(8'h0C, d); check("R2 slice idx", d[23:16], 0);
        bus_rd(8'h10, d); check("R2 cur", d, 32'h8);
        bus_rd(8'h14, d); check("R2 prev", d, 32'h0);
        pop();
        bus_rd(8'h20, d); check("R7 level after pop", occ(d), 0);
    endtask

    task automatic t_masked();
        logic [31:0] d;
        @(negedge clk); lines[32] = 1'b1;
        wait_cyc(8);
        bus_rd(8'h20, d); check("R3 masked line", occ(d), 0);
        bus_wr(8'h00, 32'h0000_0400);
        @(negedge clk); lines[3] = 1'b0;
        wait_cyc(8);
        bus_wr(8'h00, 32'h0000_0401);
        wait_cyc(8);
        bus_rd(8'h20, d); check("R3 engine off", occ(d), 0);
    endtask

    task automatic t_multi();
        logic [31:0] c, p, d;
        @(negedge clk); lines[2] = 1'b1; lines[0] = 1'b1;
        wait_cyc(8);
        bus_rd(8'h20, d); check("R4 one entry", occ(d), 1);
        bus_rd(8'h10, c); bus_rd(8'h14, p);
        check("R4 xor", c ^ p, 32'h5);
        pop();
    endtask

    task automatic t_order();
        logic [31:0] d, h0, l0, h1, l1;
        @(negedge clk); lines[1] = 1'b1; lines[36] = 1'b1;
        wait_cyc(8);
        bus_rd(8'h20, d); check("R5 two entries", occ(d), 2);
        bus_rd(8'h0C, d); check("R5 first slice", d[23:16], 0);
        bus_rd(8'h04, h0); bus_rd(8'h08, l0);
        pop();
        bus_rd(8'h0C, d); check("R5 second slice", d[23:16], 1);
        bus_rd(8'h10, d); check("R7 next head cur", d, 32'h11);
        bus_rd(8'h04, h1); bus_rd(8'h08, l1);
        check("R5 equal stamps", {h1, l1}, {h0, l0});
        pop();
    endtask

    task automatic t_stamp();
        logic [31:0] h0, l0, h1, l1;
        @(negedge clk); lines[8] = 1'b1;
        wait_cyc(20);
        lines[9] = 1'b1;
        wait_cyc(8);
        bus_rd(8'h04, h0); bus_rd(8'h08, l0);
        pop();
        bus_rd(8'h04, h1); bus_rd(8'h08, l1);
        check("R6 tick delta", {h1, l1} - {h0, l0}, 64'd20);
        pop();
    endtask

    task automatic t_irq();
        bus_wr(8'h00, 32'h0000_0203);
        @(negedge clk); lines[10] = 1'b1;
        wait_cyc(8);
        check("R10 below threshold", irq, 0);
        lines[11] = 1'b1;
        wait_cyc(8);
        check("R10 at threshold", irq, 1);
        bus_wr(8'h00, 32'h0000_0201);
        wait_cyc(3);
        check("R10 irq disabled", irq, 0);
        bus_wr(8'h00, 32'h0000_0203);
        wait_cyc(3);
        check("R10 re-enabled", irq, 1);
        pop();
        wait_cyc(3);
        check("R10 drop after pop", irq, 0);
        pop();
    endtask

    task automatic t_pop_empty();
        logic [31:0] d;
        pop();
        bus_rd(8'h20, d); check("R7 pop on empty", occ(d), 0);
        @(negedge clk); lines[15] = 1'b1;
        wait_cyc(8);
        bus_rd(8'h20, d); check("R7 level after empty pop", occ(d), 1);
        bus_rd(8'h10, d); check("R7 head intact", d, 32'h0000_8F07);
        pop();
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        for (int k = 1; k <= 33; k++) begin
            @(negedge clk); lines[12] = ~lines[12];
            wait_cyc(6);
        end
        bus_rd(8'h20, d);
        check("R9 level full", occ(d), 32);
        check("R9 overflow set", d[0], 1);
        bus_wr(8'h20, 32'h1);
        bus_rd(8'h20, d);
        check("R9 overflow cleared", d[0], 0);
        check("R9 level kept", occ(d), 32);
        for (int k = 0; k < 31; k++) pop();
        bus_rd(8'h10, d); check("R9 last kept entry", d[12], 0);
        pop();
        bus_rd(8'h20, d); check("R9 drained", occ(d), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_masks();
        t_single();
        t_masked();
        t_multi();
        t_order();
        t_stamp();
        t_irq();
        t_pop_empty();
        t_overflow();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule